// File: doc/BRIEF.md
# Vertical Reset Pulse Generator

This block watches a digitized, active-low composite sync stream and finds the broad pulses of the vertical serration interval. When it finds one, it raises a single vertical reset pulse for an external sync generator. Once the pulse is sent, the block ignores further broad pulses for a fixed number of lines, so each field yields exactly one reset. It runs on a line-locked clock, with 910 clocks per line in NTSC and 282 in PAL. A mode input chooses the line length, the detection threshold, the pulse width and the hold-off length.

A low pulse counts as a serration pulse once `sync_n` has been sampled low on a threshold number of consecutive clocks. The threshold is set well above the width of a normal line-sync tip and below half a line, so the reset starts within half a line of the start of the interval. At the start of each reset pulse a line counter is cleared. The counter then advances once per line and stops at its all-ones value, and downstream gating logic reads it from `line_count`.

Control is a three-state machine. ARMED is the reset state. A detection in ARMED moves it to FIRE and clears the line counter. FIRE drives `vr_pulse` and moves to HOLD after the pulse width has elapsed. HOLD moves back to ARMED once the line counter reaches the hold-off line count. Detections in FIRE and HOLD are dropped.

Top module: `vsync_reset_gen`

## Requirements
- R1: `ntsc_sel` = 1 selects the NTSC set of line length, detection threshold, pulse width and hold-off lines; `ntsc_sel` = 0 selects the PAL set.
- R2: A low run on `sync_n` shorter than the detection threshold produces no reset pulse.
- R3: When armed, `vr_pulse` rises on the clock edge that samples the threshold-th consecutive low of `sync_n`.
- R4: Each reset pulse stays high for exactly the mode's pulse-width number of clocks.
- R5: Detections from the start of a pulse until the edge where `line_count` reaches the hold-off line count are ignored and not queued.
- R6: A detection one clock after the hold-off ends produces a reset pulse.
- R7: `line_count` is 0 from the edge a pulse starts and increments by one every line-length clocks after that.
- R8: `line_count` saturates at 2^LINE_CNT_W - 1.
- R9: During and right after reset, `vr_pulse` is 0, `line_count` is 0 and the block is armed.
- R10: A single high sample on `sync_n` restarts the low-run measurement, so two short lows separated by a high produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked working clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntsc_sel | input | 1 | 1 = NTSC, 0 = PAL |
| sync_n | input | 1 | Digitized composite sync, low during sync tips |
| vr_pulse | output | 1 | Vertical reset pulse |
| line_count | output | LINE_CNT_W | Lines since the last reset pulse, saturating |

## Verification
The assertions compute the pulse width, the threshold and the hold-off window from `ntsc_sel`, so they assume the mode is held steady for at least a hold-off window around each pulse. They also assume `sync_n` is synchronous to `clk`. The bench changes mode only after a full hold-off has passed with `sync_n` high. It drives `sync_n` only on falling clock edges, and all of its timing is counted in whole clocks from the start of a stimulus.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HOLD  = 2'd2
    } vrg_state_t;
endpackage

// File: rtl/vrg_width_meter.sv
module vrg_width_meter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    input  logic [CW-1:0] thr,
    output logic          long_low
);
    logic [CW-1:0] run_q;

    // Count consecutive low samples, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (sync_n) begin
            run_q <= '0;
        end else if (run_q < thr) begin
            run_q <= run_q + 1'b1;
        end
    end

    // One-cycle strobe on the sample that completes the threshold run
    assign long_low = !sync_n && (run_q == thr - 1'b1);
endmodule

// File: rtl/vrg_line_timer.sv
module vrg_line_timer #(
    parameter int CW  = 10,
    parameter int LCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [CW-1:0]  line_len,
    output logic [LCW-1:0] line_cnt
);
    localparam logic [LCW-1:0] LMAX = '1;

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            line_cnt <= '0;
        end else if (clr) begin
            pos_q    <= '0;
            line_cnt <= '0;
        end else if (pos_q >= line_len - 1'b1) begin
            pos_q <= '0;
            if (line_cnt != LMAX) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/vrg_fsm.sv
module vrg_fsm
    import vrg_pkg::*;
#(
    parameter int CW  = 10,
    parameter int LCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           long_low,
    input  logic [CW-1:0]  pw,
    input  logic [LCW-1:0] hold,
    input  logic [LCW-1:0] line_cnt,
    output logic           vr,
    output logic           clr
);
    vrg_state_t    state_q, state_d;
    logic [CW-1:0] wcnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Pulse width counter, runs only while firing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state_q == ST_FIRE) begin
            wcnt_q <= wcnt_q + 1'b1;
        end else begin
            wcnt_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (long_low)              state_d = ST_FIRE;
            ST_FIRE:  if (wcnt_q == pw - 1'b1)   state_d = ST_HOLD;
            ST_HOLD:  if (line_cnt >= hold)      state_d = ST_ARMED;
            default:                             state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        vr  = (state_q == ST_FIRE);
        clr = (state_q == ST_ARMED) && long_low;
    end
endmodule

// File: rtl/vsync_reset_gen.sv
module vsync_reset_gen #(
    parameter int N_LINE_CLKS  = 910,
    parameter int P_LINE_CLKS  = 282,
    parameter int N_SERR_CLKS  = 113,
    parameter int P_SERR_CLKS  = 35,
    parameter int N_PULSE_CLKS = 200,
    parameter int P_PULSE_CLKS = 49,
    parameter int N_HOLD_LINES = 256,
    parameter int P_HOLD_LINES = 304,
    parameter int LINE_CNT_W   = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ntsc_sel,
    input  logic                  sync_n,
    output logic                  vr_pulse,
    output logic [LINE_CNT_W-1:0] line_count
);
    localparam int MAX_LINE = (N_LINE_CLKS > P_LINE_CLKS) ? N_LINE_CLKS : P_LINE_CLKS;
    localparam int MAX_PW   = (N_PULSE_CLKS > P_PULSE_CLKS) ? N_PULSE_CLKS : P_PULSE_CLKS;
    localparam int CW       = $clog2(MAX_LINE + MAX_PW + 1);

    logic [CW-1:0]         line_len, thr, pw;
    logic [LINE_CNT_W-1:0] hold;
    logic                  long_low, clr;

    assign line_len = ntsc_sel ? CW'(N_LINE_CLKS)  : CW'(P_LINE_CLKS);
    assign thr      = ntsc_sel ? CW'(N_SERR_CLKS)  : CW'(P_SERR_CLKS);
    assign pw       = ntsc_sel ? CW'(N_PULSE_CLKS) : CW'(P_PULSE_CLKS);
    assign hold     = ntsc_sel ? LINE_CNT_W'(N_HOLD_LINES) : LINE_CNT_W'(P_HOLD_LINES);

    vrg_width_meter #(.CW(CW)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .thr      (thr),
        .long_low (long_low)
    );

    vrg_line_timer #(.CW(CW), .LCW(LINE_CNT_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .line_len (line_len),
        .line_cnt (line_count)
    );

    vrg_fsm #(.CW(CW), .LCW(LINE_CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_low (long_low),
        .pw       (pw),
        .hold     (hold),
        .line_cnt (line_count),
        .vr       (vr_pulse),
        .clr      (clr)
    );
endmodule

// File: rtl/vrg_checker.sv
module vrg_checker #(
    parameter int N_LINE_CLKS  = 910,
    parameter int P_LINE_CLKS  = 282,
    parameter int N_SERR_CLKS  = 113,
    parameter int P_SERR_CLKS  = 35,
    parameter int N_PULSE_CLKS = 200,
    parameter int P_PULSE_CLKS = 49,
    parameter int N_HOLD_LINES = 256,
    parameter int P_HOLD_LINES = 304,
    parameter int LINE_CNT_W   = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ntsc_sel,
    input logic                  sync_n,
    input logic                  vr_pulse,
    input logic [LINE_CNT_W-1:0] line_count
);
    localparam logic [LINE_CNT_W-1:0] LMAX = '1;
    localparam int unsigned SAT = 32'hFFFF_FFF0;

    int unsigned pw_sel, thr_sel, win_sel;
    int unsigned hi_run, low_run, since;
    logic        vr_d;

    assign pw_sel  = ntsc_sel ? N_PULSE_CLKS : P_PULSE_CLKS;
    assign thr_sel = ntsc_sel ? N_SERR_CLKS  : P_SERR_CLKS;
    assign win_sel = ntsc_sel ? N_HOLD_LINES * N_LINE_CLKS : P_HOLD_LINES * P_LINE_CLKS;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= 0;
            low_run <= 0;
            since   <= SAT;
            vr_d    <= 1'b0;
        end else begin
            vr_d    <= vr_pulse;
            hi_run  <= vr_pulse ? hi_run + 1 : 0;
            low_run <= sync_n ? 0 : ((low_run < SAT) ? low_run + 1 : low_run);
            if (vr_pulse && !vr_d)  since <= 1;
            else if (since < SAT)   since <= since + 1;
        end
    end

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vr_pulse |-> (hi_run < pw_sel));

    assert_pulse_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vr_pulse) |-> (hi_run == pw_sel));

    assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_pulse) |-> (low_run >= thr_sel));

    assert_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_pulse) |-> (since > win_sel));

    assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_pulse) |-> (line_count == '0));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(vr_pulse) && (line_count != $past(line_count)))
            |-> (line_count == LINE_CNT_W'($past(line_count) + 1'b1)));

    assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(vr_pulse) && ($past(line_count) == LMAX)) |-> (line_count == LMAX));
endmodule

bind vsync_reset_gen vrg_checker #(
    .N_LINE_CLKS  (N_LINE_CLKS),
    .P_LINE_CLKS  (P_LINE_CLKS),
    .N_SERR_CLKS  (N_SERR_CLKS),
    .P_SERR_CLKS  (P_SERR_CLKS),
    .N_PULSE_CLKS (N_PULSE_CLKS),
    .P_PULSE_CLKS (P_PULSE_CLKS),
    .N_HOLD_LINES (N_HOLD_LINES),
    .P_HOLD_LINES (P_HOLD_LINES),
    .LINE_CNT_W   (LINE_CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ntsc_sel   (ntsc_sel),
    .sync_n     (sync_n),
    .vr_pulse   (vr_pulse),
    .line_count (line_count)
);

// File: tb/vsync_reset_gen_tb.sv
`timescale 1ns/1ps
module vsync_reset_gen_tb;
    localparam int NL = 40, PL = 24, NT = 5, PT = 3, NP = 8, PP = 4, NH = 6, PH = 8;
    localparam int LCW  = 4;
    localparam int LMAX = (1 << LCW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ntsc_sel = 1'b1;
    logic           sync_n = 1'b1;
    logic           vr_pulse;
    logic [LCW-1:0] line_count;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    vsync_reset_gen #(
        .N_LINE_CLKS(NL), .P_LINE_CLKS(PL), .N_SERR_CLKS(NT), .P_SERR_CLKS(PT),
        .N_PULSE_CLKS(NP), .P_PULSE_CLKS(PP), .N_HOLD_LINES(NH), .P_HOLD_LINES(PH),
        .LINE_CNT_W(LCW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ntsc_sel(ntsc_sel), .sync_n(sync_n),
        .vr_pulse(vr_pulse), .line_count(line_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        sync_n = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive w low samples then high; report first edge with vr high and high count
    task automatic run_pulse(input int w, input int total, output int first_hi, output int hi_cnt);
        first_hi = 0;
        hi_cnt   = 0;
        for (int i = 1; i <= total; i++) begin
            sync_n = (i <= w) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (vr_pulse) begin
                if (first_hi == 0) first_hi = i;
                hi_cnt++;
            end
        end
        sync_n = 1'b1;
    endtask

    task automatic run_mode(input bit m);
        int L, T, P, H, fh, hc, t0;
        L = m ? NL : PL; T = m ? NT : PT; P = m ? NP : PP; H = m ? NH : PH;
        ntsc_sel = m;
        idle(2);

        // R2, R3, R4: sweep low-run width around the threshold (R1 via mode values)
        for (int w = 1; w <= T + 3; w++) begin
            run_pulse(w, ((w > T) ? w : T) + P + 2, fh, hc);
            if (w < T) begin
                check("R2 short low no pulse", hc, 0);
            end else begin
                check("R3 pulse start edge", fh, T);
                check("R4 pulse width", hc, P);
                check("R1 mode pulse width", hc, m ? NP : PP);
            end
            idle(H * L);
        end

        // R10: high sample restarts measurement
        begin
            int hits = 0;
            for (int i = 1; i <= 2 * T + P; i++) begin
                sync_n = (i == T) ? 1'b1 : ((i < 2 * T) ? 1'b0 : 1'b1);
                @(negedge clk);
                if (vr_pulse) hits++;
            end
            check("R10 split low no pulse", hits, 0);
        end
        idle(2);

        // R5 / R6: ignored detections inside the window, re-arm right after it
        t0 = T + P + 4;
        run_pulse(T + 2, t0, fh, hc);
        check("R3 hold test fire", fh, T);
        run_pulse(T + 2, T + 3, fh, hc);
        check("R5 detection in hold ignored", hc, 0);
        idle(H * L - t0 - (T + 3));
        run_pulse(T + 1, T + 2, fh, hc);
        check("R5 detection at window edge ignored", hc, 0);
        run_pulse(T, T + P + 2, fh, hc);
        check("R6 re-armed after window", fh, T);
        check("R6 pulse width", hc, P);
        idle(H * L);

        // R7 / R8: line counting and saturation after a fresh pulse
        run_pulse(T, T + 1, fh, hc);
        check("R7 fire for count", fh, T);
        for (int e = T + 2; e <= T + (LMAX + 2) * L; e++) begin
            int rel, exp;
            @(negedge clk);
            rel = e - T;
            exp = (rel / L > LMAX) ? LMAX : rel / L;
            if (exp == LMAX) check("R8 saturate", int'(line_count), exp);
            else             check("R7 line count", int'(line_count), exp);
        end
        check("R5 no stray pulse", int'(vr_pulse), 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 vr in reset", int'(vr_pulse), 0);
        check("R9 count in reset", int'(line_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 vr after reset", int'(vr_pulse), 0);
        check("R9 count after reset", int'(line_count), 0);
        // Armed from reset: a threshold run fires at once
        begin
            int fh, hc;
            run_pulse(NT, NT + NP + 2, fh, hc);
            check("R9 armed after reset", fh, NT);
        end
        idle(NH * NL);
        run_mode(1'b1);
        idle(PH * PL);
        run_mode(1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule